// File: doc/BRIEF.md
# Serial Port Register Block

This block is the CPU-facing register file of a simple serial port. It holds a status register, two control registers, a mode register and a two-byte baud divisor. It also holds a one-byte receive slot and the logic behind three level interrupt lines. The CPU reaches it through a byte bus with a 3-bit offset. Reads return data combinationally in the access cycle. All side effects take place at the clock edge that closes the access.

Received characters come in on a valid/ready byte stream and wait in the single slot until the CPU reads them. Transmitted characters leave on a byte stream as a one-cycle valid pulse, in the same cycle as the data write that sends them. Bit-level framing, baud timing and parity belong to other blocks. A power-reduction input holds the whole block in its reset state.

Offsets: 0 status, 1 control, 2 mode, 3 unmapped, 4 divisor low, 5 divisor high, 6 data, 7 unmapped. Status bits: 7 receive-done flag (RXC), 6 transmit-done flag (TXC), 5 transmit-empty flag (DRE), 1 and 0 plain storage. Control bits: 7 receive-done interrupt enable, 6 transmit-done interrupt enable, 5 transmit-empty interrupt enable, 4 receiver enable, 3 transmitter enable, 2 size bit 2. Bit 1 of the control register is read-only and always 0. Mode bits: 2 size bit 1, 1 size bit 0.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, status reads 0x20, control reads 0x00, mode reads 0x06, both divisor bytes read 0, and data reads 0. All interrupt outputs are low and the receive slot is empty.
- R2: The 3-bit size code is {control bit 2, mode bit 2, mode bit 1}. Codes 0, 1, 2 and 3 keep the low 5, 6, 7 and 8 bits of a received byte when it is read. Code 7 keeps 8 bits.
- R3: A write to the control or mode register that leaves the size code at 4, 5 or 6 keeps the mask that was in force before the write.
- R4: rx_ready_o is high only when the receiver is enabled, the slot is empty, power reduction is low and no bus access is under way. A byte offered while rx_ready_o is low is not stored.
- R5: Accepting a byte stores it and sets RXC. If the receive-done enable is set, irq_rx_done_o goes high at the same edge.
- R6: With the receiver enabled, a data read returns the masked byte, or 0 when the slot is empty. The read empties the slot, clears RXC and drops irq_rx_done_o.
- R7: With the receiver disabled, a data read returns 0 and changes no state.
- R8: With the transmitter disabled, a data write does nothing. Otherwise, in the write cycle, tx_valid_o is 1 and tx_data_o carries the byte, and at the edge TXC and DRE are set. If the transmit-done enable is set, irq_tx_done_o rises and TXC is cleared instead. If the transmit-empty enable is set, irq_tx_empty_o rises.
- R9: A status write changes only bits 6, 1 and 0. Writing a 1 to bit 6 also drops irq_tx_done_o. TXC reads 0 after any status write.
- R10: A control write changes only the bits under mask 0xFD. If it clears the receiver enable, the buffered byte is discarded and RXC is left as it was. After the write, each interrupt output equals its new enable bit ANDed with its flag.
- R11: The mode register and the low divisor byte store all 8 bits. The high divisor byte stores only its low 4 bits. Offsets 3 and 7 read 0 and ignore writes.
- R12: While pwr_off_i is high, reads return 0, writes are ignored, rx_ready_o and tx_valid_o are low, and the block returns to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_off_i | input | 1 | Power reduction; holds block in reset state |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive slot can accept |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_rx_done_o | output | 1 | Receive-done interrupt |
| irq_tx_done_o | output | 1 | Transmit-done interrupt |
| irq_tx_empty_o | output | 1 | Transmit-empty interrupt |

## Verification
The checker enforces the following on every cycle:
- the gating of rx_ready_o;
- that an accepted byte fills the slot and sets RXC, with irq_rx_done_o following its enable;
- that irq_rx_done_o never stands without RXC;
- the flag and interrupt updates after a transmit;
- the zero read data and low interrupts under power reduction.

The bench scenarios are the only way to show the data-dependent effects:
- the masking of received bytes, swept over all 256 values for each valid size code, and the persistence of the mask through reserved codes;
- the status and control write masks;
- the discard of a buffered byte when the receiver is disabled;
- the divisor and unmapped-offset behaviour.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int REG_W = 8;

  localparam logic [2:0] OFF_STA  = 3'd0;
  localparam logic [2:0] OFF_CTL  = 3'd1;
  localparam logic [2:0] OFF_MODE = 3'd2;
  localparam logic [2:0] OFF_DIVL = 3'd4;
  localparam logic [2:0] OFF_DIVH = 3'd5;
  localparam logic [2:0] OFF_DATA = 3'd6;

  // status bits
  localparam int ST_RXC = 7;
  localparam int ST_TXC = 6;
  localparam int ST_DRE = 5;
  // control bits
  localparam int CT_RXIE = 7;
  localparam int CT_TXIE = 6;
  localparam int CT_DRIE = 5;
  localparam int CT_RXEN = 4;
  localparam int CT_TXEN = 3;
  localparam int CT_SZ2  = 2;
  // mode bits
  localparam int MD_SZ1 = 2;
  localparam int MD_SZ0 = 1;

  localparam logic [REG_W-1:0] STA_WMASK = 8'h43;
  localparam logic [REG_W-1:0] CTL_WMASK = 8'hFD;
  localparam logic [REG_W-1:0] STA_RST   = 8'h20;
  localparam logic [REG_W-1:0] MODE_RST  = 8'h06;

  function automatic logic [REG_W-1:0] low_ones(input int n);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/char_width_sel.sv
module char_width_sel
  import serial_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [2:0]       code_i,
  output logic [REG_W-1:0] mask_o
);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= low_ones(8);
    else if (clr_i)  mask_q <= low_ones(8);
    else if (upd_i) begin
      case (code_i)
        3'd0:    mask_q <= low_ones(5);
        3'd1:    mask_q <= low_ones(6);
        3'd2:    mask_q <= low_ones(7);
        3'd3:    mask_q <= low_ones(8);
        3'd7:    mask_q <= low_ones(8);
        default: mask_q <= mask_q;  // reserved codes
      endcase
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/rx_slot.sv
module rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (pop_i || flush_i) full_q <= 1'b0;
      if (push_i) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int DIVH_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_off_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             rx_valid_i,
  input  logic [REG_W-1:0] rx_data_i,
  output logic             rx_ready_o,
  output logic             tx_valid_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             irq_rx_done_o,
  output logic             irq_tx_done_o,
  output logic             irq_tx_empty_o
);
  localparam int DIVH_PAD = REG_W - DIVH_W;

  logic [REG_W-1:0]  sta_q, sta_d, ctl_q, mode_q, divl_q;
  logic [DIVH_W-1:0] divh_q;
  logic irq_rx_q, irq_rx_d, irq_tx_q, irq_tx_d, irq_dre_q, irq_dre_d;

  logic             rx_full;
  logic [REG_W-1:0] rx_byte, char_mask;

  wire acc     = bus_sel_i & ~pwr_off_i;
  wire wr      = acc & bus_we_i;
  wire rd      = acc & ~bus_we_i;
  wire rx_en   = ctl_q[CT_RXEN];
  wire tx_en   = ctl_q[CT_TXEN];
  wire sta_wr  = wr && bus_addr_i == OFF_STA;
  wire ctl_wr  = wr && bus_addr_i == OFF_CTL;
  wire mode_wr = wr && bus_addr_i == OFF_MODE;
  wire send    = wr && bus_addr_i == OFF_DATA && tx_en;
  wire take    = rd && bus_addr_i == OFF_DATA && rx_en;

  wire [REG_W-1:0] ctl_next = (bus_wdata_i & CTL_WMASK) | (ctl_q & ~CTL_WMASK);
  wire [REG_W-1:0] mode_cur = mode_wr ? bus_wdata_i : mode_q;
  wire [2:0] size_code = {ctl_wr ? ctl_next[CT_SZ2] : ctl_q[CT_SZ2],
                          mode_cur[MD_SZ1], mode_cur[MD_SZ0]};

  assign rx_ready_o = rx_en & ~rx_full & ~bus_sel_i & ~pwr_off_i;
  wire push = rx_valid_i & rx_ready_o;

  char_width_sel u_width (
    .clk_i, .rst_ni, .clr_i(pwr_off_i),
    .upd_i(ctl_wr | mode_wr), .code_i(size_code), .mask_o(char_mask)
  );

  rx_slot #(.DATA_W(REG_W)) u_slot (
    .clk_i, .rst_ni, .clr_i(pwr_off_i),
    .push_i(push), .data_i(rx_data_i), .pop_i(take),
    .flush_i(ctl_wr & ~ctl_next[CT_RXEN]),
    .full_o(rx_full), .data_o(rx_byte)
  );

  // flag and interrupt next state; receive push cannot overlap a bus access
  always_comb begin
    sta_d     = sta_q;
    irq_rx_d  = irq_rx_q;
    irq_tx_d  = irq_tx_q;
    irq_dre_d = irq_dre_q;
    if (sta_wr) begin
      sta_d = (bus_wdata_i & STA_WMASK) | (sta_q & ~STA_WMASK);
      if (bus_wdata_i[ST_TXC]) begin
        sta_d[ST_TXC] = 1'b0;
        irq_tx_d      = 1'b0;
      end
    end
    if (ctl_wr) begin
      irq_rx_d  = ctl_next[CT_RXIE] & sta_q[ST_RXC];
      irq_tx_d  = ctl_next[CT_TXIE] & sta_q[ST_TXC];
      irq_dre_d = ctl_next[CT_DRIE] & sta_q[ST_DRE];
    end
    if (send) begin
      sta_d[ST_TXC] = 1'b1;
      sta_d[ST_DRE] = 1'b1;
      if (ctl_q[CT_TXIE]) begin
        irq_tx_d      = 1'b1;
        sta_d[ST_TXC] = 1'b0;
      end
      if (ctl_q[CT_DRIE]) irq_dre_d = 1'b1;
    end
    if (take) begin
      sta_d[ST_RXC] = 1'b0;
      irq_rx_d      = 1'b0;
    end
    if (push) begin
      sta_d[ST_RXC] = 1'b1;
      if (ctl_q[CT_RXIE]) irq_rx_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || pwr_off_i) begin
      sta_q     <= STA_RST;
      ctl_q     <= '0;
      mode_q    <= MODE_RST;
      divl_q    <= '0;
      divh_q    <= '0;
      irq_rx_q  <= 1'b0;
      irq_tx_q  <= 1'b0;
      irq_dre_q <= 1'b0;
    end else begin
      sta_q     <= sta_d;
      irq_rx_q  <= irq_rx_d;
      irq_tx_q  <= irq_tx_d;
      irq_dre_q <= irq_dre_d;
      if (ctl_wr)  ctl_q  <= ctl_next;
      if (mode_wr) mode_q <= bus_wdata_i;
      if (wr && bus_addr_i == OFF_DIVL) divl_q <= bus_wdata_i;
      if (wr && bus_addr_i == OFF_DIVH) divh_q <= bus_wdata_i[DIVH_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        OFF_STA:  bus_rdata_o = sta_q;
        OFF_CTL:  bus_rdata_o = ctl_q;
        OFF_MODE: bus_rdata_o = mode_q;
        OFF_DIVL: bus_rdata_o = divl_q;
        OFF_DIVH: bus_rdata_o = {{DIVH_PAD{1'b0}}, divh_q};
        OFF_DATA: bus_rdata_o = (rx_en && rx_full) ? (rx_byte & char_mask) : '0;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign tx_valid_o     = send;
  assign tx_data_o      = bus_wdata_i;
  assign irq_rx_done_o  = irq_rx_q;
  assign irq_tx_done_o  = irq_tx_q;
  assign irq_tx_empty_o = irq_dre_q;
endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_off_i,
  input logic       rx_valid_i,
  input logic       rx_ready_o,
  input logic       tx_valid_o,
  input logic [7:0] bus_rdata_o,
  input logic       irq_rx_done_o,
  input logic       irq_tx_done_o,
  input logic       irq_tx_empty_o,
  input logic [7:0] sta_q,
  input logic [7:0] ctl_q,
  input logic       rx_full
);
  // R4
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (ctl_q[4] && !rx_full && !pwr_off_i));

  // R5
  accept_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && !pwr_off_i) |=> (rx_full && sta_q[7] && irq_rx_done_o == ctl_q[7]));

  // R6
  rx_irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_done_o |-> sta_q[7]);

  // R8
  tx_done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && ctl_q[6]) |=> (irq_tx_done_o && !sta_q[6] && sta_q[5]));

  // R12
  pwr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |-> (bus_rdata_o == 8'h00 && !rx_ready_o && !tx_valid_o));

  // R12
  pwr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |=> (!irq_rx_done_o && !irq_tx_done_o && !irq_tx_empty_o && sta_q == 8'h20));
endmodule

bind serial_port_regs serial_port_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_off_i(pwr_off_i),
  .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .tx_valid_o(tx_valid_o),
  .bus_rdata_o(bus_rdata_o), .irq_rx_done_o(irq_rx_done_o),
  .irq_tx_done_o(irq_tx_done_o), .irq_tx_empty_o(irq_tx_empty_o),
  .sta_q(sta_q), .ctl_q(ctl_q), .rx_full(rx_full)
);

// File: tb/serial_port_regs_tb.sv
`timescale 1ns/1ps
module serial_port_regs_tb;
  logic       clk = 0, rst_n = 0, pwr = 0;
  logic       sel = 0, we = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq_rx, irq_tx, irq_dre;

  int checks = 0, errors = 0;
  bit done = 0;
  logic       last_txv;
  logic [7:0] last_txd;
  logic [7:0] rv;
  logic       acc;

  always #2 clk = ~clk;

  serial_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_off_i(pwr),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .irq_rx_done_o(irq_rx), .irq_tx_done_o(irq_tx), .irq_tx_empty_o(irq_dre)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    #1;
    last_txv = tx_valid;
    last_txd = tx_data;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1;
    d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic push(input logic [7:0] d, output logic ok);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #1;
    ok = rx_ready;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 status", 3'd0, 8'h20);
    rd_chk("R1 control", 3'd1, 8'h00);
    rd_chk("R1 mode", 3'd2, 8'h06);
    rd_chk("R1 divl", 3'd4, 8'h00);
    rd_chk("R1 divh", 3'd5, 8'h00);
    rd_chk("R1 data", 3'd6, 8'h00);
    chk("R1 irqs", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h00);
    chk("R4 ready when disabled", {7'd0, rx_ready}, 8'h00);

    // R11 divisor, mode, unmapped
    wr(3'd5, 8'hFF); rd_chk("R11 divh", 3'd5, 8'h0F);
    wr(3'd4, 8'hA5); rd_chk("R11 divl", 3'd4, 8'hA5);
    wr(3'd2, 8'hFF); rd_chk("R11 mode", 3'd2, 8'hFF);
    wr(3'd3, 8'h55); rd_chk("R11 off3", 3'd3, 8'h00);
    wr(3'd7, 8'h55); rd_chk("R11 off7", 3'd7, 8'h00);
    rd_chk("R11 status kept", 3'd0, 8'h20);
    wr(3'd2, 8'h06);

    // R7 receiver disabled
    push(8'h5A, acc);
    chk("R4 not accepted", {7'd0, acc}, 8'h00);
    rd_chk("R7 data disabled", 3'd6, 8'h00);
    rd_chk("R7 status unchanged", 3'd0, 8'h20);

    // R2 exhaustive masking sweep
    for (int c = 0; c < 8; c++) begin
      if (c >= 4 && c <= 6) continue;
      wr(3'd1, 8'h10 | (c[2] ? 8'h04 : 8'h00));
      wr(3'd2, {5'd0, c[1:0], 1'b0});
      for (int b = 0; b < 256; b++) begin
        int w;
        w = (c == 7) ? 8 : 5 + c;
        push(b[7:0], acc);
        chk("R2 accept", {7'd0, acc}, 8'h01);
        rd_chk("R2 masked data", 3'd6, b[7:0] & 8'((1 << w) - 1));
      end
    end

    // R3 reserved codes keep mask
    wr(3'd1, 8'h10); wr(3'd2, 8'h00);
    wr(3'd1, 8'h14);
    push(8'hFF, acc); rd_chk("R3 code4", 3'd6, 8'h1F);
    wr(3'd2, 8'h02);
    push(8'hFF, acc); rd_chk("R3 code5", 3'd6, 8'h1F);
    wr(3'd2, 8'h04);
    push(8'hFF, acc); rd_chk("R3 code6", 3'd6, 8'h1F);
    wr(3'd2, 8'h06);
    push(8'hFF, acc); rd_chk("R3 code7", 3'd6, 8'hFF);

    // R4 / R6 slot behaviour
    wr(3'd1, 8'h10);
    rd_chk("R6 empty read", 3'd6, 8'h00);
    push(8'h11, acc);
    chk("R4 ready after fill", {7'd0, rx_ready}, 8'h00);
    push(8'h22, acc);
    chk("R4 full refuses", {7'd0, acc}, 8'h00);
    rd_chk("R6 first byte", 3'd6, 8'h11);
    rd_chk("R6 then empty", 3'd6, 8'h00);
    @(negedge clk);
    sel = 1; we = 0; addr = 3'd0; rx_valid = 1; rx_data = 8'h66;
    #1;
    chk("R4 stall on bus access", {7'd0, rx_ready}, 8'h00);
    @(negedge clk);
    sel = 0; rx_valid = 0;
    rd_chk("R4 nothing stored", 3'd6, 8'h00);

    // R5 receive interrupt
    wr(3'd1, 8'h90);
    push(8'h33, acc);
    chk("R5 irq_rx", {7'd0, irq_rx}, 8'h01);
    rd_chk("R5 RXC set", 3'd0, 8'hA0);
    rd_chk("R6 read byte", 3'd6, 8'h33);
    chk("R6 irq dropped", {7'd0, irq_rx}, 8'h00);
    rd_chk("R6 RXC cleared", 3'd0, 8'h20);

    // R10 flush and recompute
    wr(3'd1, 8'h10);
    push(8'h44, acc);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h10);
    rd_chk("R10 RXC kept", 3'd0, 8'hA0);
    rd_chk("R10 discarded", 3'd6, 8'h00);
    push(8'h55, acc);
    chk("R10 no irq without enable", {7'd0, irq_rx}, 8'h00);
    wr(3'd1, 8'h90);
    chk("R10 irq_rx recompute", {7'd0, irq_rx}, 8'h01);
    wr(3'd1, 8'hFF);
    rd_chk("R10 control mask", 3'd1, 8'hFD);
    chk("R10 irqs", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h05);
    rd_chk("R10 byte survives", 3'd6, 8'h55);
    wr(3'd1, 8'h00);
    chk("R10 irqs off", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h00);

    // R8 transmit
    wr(3'd6, 8'h77);
    chk("R8 disabled no tx", {7'd0, last_txv}, 8'h00);
    rd_chk("R8 disabled status", 3'd0, 8'h20);
    wr(3'd1, 8'h08);
    wr(3'd6, 8'h78);
    chk("R8 tx valid", {7'd0, last_txv}, 8'h01);
    chk("R8 tx data", last_txd, 8'h78);
    rd_chk("R8 TXC DRE", 3'd0, 8'h60);

    // R9 status write mask
    wr(3'd0, 8'h40); rd_chk("R9 TXC clear", 3'd0, 8'h20);
    wr(3'd0, 8'hFF); rd_chk("R9 mask", 3'd0, 8'h23);
    wr(3'd0, 8'h00); rd_chk("R9 low bits", 3'd0, 8'h20);

    wr(3'd1, 8'h68);
    chk("R10 dre irq on enable", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h01);
    wr(3'd6, 8'h99);
    chk("R8 tx data irq", last_txd, 8'h99);
    chk("R8 irqs", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h03);
    rd_chk("R8 TXC self clear", 3'd0, 8'h20);
    wr(3'd0, 8'h40);
    chk("R9 irq_tx dropped", {7'd0, irq_tx}, 8'h00);

    // R12 power reduction
    wr(3'd1, 8'h98);
    wr(3'd4, 8'h12);
    @(negedge clk); pwr = 1;
    rd_chk("R12 read zero", 3'd4, 8'h00);
    wr(3'd4, 8'h34);
    chk("R12 irqs low", {5'd0, irq_rx, irq_tx, irq_dre}, 8'h00);
    chk("R12 ready low", {7'd0, rx_ready}, 8'h00);
    @(negedge clk); pwr = 0;
    rd_chk("R12 divl reset", 3'd4, 8'h00);
    rd_chk("R12 control reset", 3'd1, 8'h00);
    rd_chk("R12 status reset", 3'd0, 8'h20);
    rd_chk("R12 mode reset", 3'd2, 8'h06);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule